// File: doc/BRIEF.md
# Quadrant Almost-Empty Flag Bus

This block presents the almost-empty status of a 32-queue buffer on an 8-bit flag bus, one quadrant of eight queues at a time. The status bits come from elsewhere, typically threshold comparators per queue. This block only decides which quadrant is on the bus and marks where the polling sequence begins.

In direct mode a host selects the quadrant by raising a strobe while it drives the shared address bus. The two low address bits name the quadrant. The three high bits must equal this device's identifier, and the bits between them play no part. In polled mode the block steps through the quadrants on its own, one per clock. A sync output marks the cycle in which quadrant 0 is shown, so a receiver can line up the frames it collects. There is no read-enable input: neither selection nor polling depends on reads.

Top module: `aeflag_quad_bus`

## Requirements
- R1: After reset, the direct selection and the poll counter are both quadrant 0. The bus shows queues 0 to 7, and in direct mode the sync output is low.
- R2: With quadrant q selected, bus bit i carries status bit 8q+i. The bus follows changes of the status inputs in the same cycle.
- R3: Mode select 0 is direct mode and 1 is polled mode. In direct mode, a clock edge with the strobe high and address bits [7:5] equal to the device ID loads address bits [1:0] as the quadrant. The new quadrant is on the bus from the following cycle.
- R4: Address bits [4:2] have no effect on which quadrant is selected.
- R5: In direct mode the selection is unchanged when the strobe is low, or when address bits [7:5] differ from the device ID.
- R6: In polled mode the shown quadrant advances by one on every clock edge and wraps from 3 to 0. While direct mode is active the poll counter is held at 0, so polling always begins at quadrant 0.
- R7: The sync output is high exactly when polled mode is active and quadrant 0 is on the bus. It is always low in direct mode.
- R8: In polled mode the strobe is ignored. The direct selection made before polling is shown again once direct mode resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ae_status | input | 32 | Almost-empty status, one bit per queue |
| rd_addr | input | 8 | Shared address bus: [7:5] device ID, [1:0] quadrant |
| flag_strobe | input | 1 | Direct-mode quadrant selection strobe |
| poll_mode | input | 1 | 0 = direct mode, 1 = polled mode |
| dev_id | input | 3 | Identifier of this device |
| flag_bus | output | 8 | Almost-empty flags of the shown quadrant |
| quad_sync | output | 1 | High while quadrant 0 is shown in polled mode |

## Verification
The status inputs hold a different byte value in each quadrant, so every quadrant can be told from every other on the bus. A single walking bit confirms the bit order inside a quadrant. Direct selections use addresses with the middle bits set in different ways, with a wrong identifier, and with the strobe low; these separate a correct decode from one that reads the wrong address bits or skips the ID compare. Polling runs for two full rounds, once after reset and once after direct mode. This exposes a wrong step, a wrong wrap or a misplaced sync. A matching strobe during polling, followed by a return to direct mode, shows whether the strobe leaked into the stored selection.

// File: rtl/aeflag_pkg.sv
// Package: shared mode encoding and default geometry for the flag bus.
// Assumes: the queue count is a multiple of the bus width.
package aeflag_pkg;
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLL   = 1'b1
    } flag_mode_e;

    localparam int DEF_NUM_Q  = 32;
    localparam int DEF_BUS_W  = 8;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_ID_W   = 3;
endpackage

// File: rtl/aeflag_dir_sel.sv
// Module: holds the quadrant chosen in direct mode.
// Loads the quadrant field when the strobe is high, the ID field matches
// and the block is in direct mode. Assumes QW bits cover every quadrant.
module aeflag_dir_sel #(
    parameter int QW   = 2,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            direct_en,
    input  logic            strobe,
    input  logic [ID_W-1:0] id_field,
    input  logic [ID_W-1:0] dev_id,
    input  logic [QW-1:0]   quad_field,
    output logic [QW-1:0]   dir_q
);
    logic take;

    // Accept a selection only for this device in direct mode.
    always_comb begin
        take = direct_en && strobe && (id_field == dev_id);
    end

    // Register the selected quadrant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (take) begin
            dir_q <= quad_field;
        end
    end
endmodule

// File: rtl/aeflag_poll_ctr.sv
// Module: quadrant counter for polled mode.
// Advances one quadrant per clock while enabled and wraps after the last.
// Held at quadrant 0 while disabled, so each polling run starts at 0.
module aeflag_poll_ctr #(
    parameter int NQUAD = 4,
    parameter int QW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_en,
    output logic [QW-1:0] poll_q
);
    localparam logic [QW-1:0] LAST_Q = QW'(NQUAD - 1);

    // Step, wrap, or park at quadrant 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !poll_en) begin
            poll_q <= '0;
        end else if (poll_q == LAST_Q) begin
            poll_q <= '0;
        end else begin
            poll_q <= poll_q + 1'b1;
        end
    end
endmodule

// File: rtl/aeflag_quad_mux.sv
// Module: slices the status vector into quadrants and picks one.
// Bit i of the output carries status bit BUS_W*sel+i. Purely combinational.
module aeflag_quad_mux #(
    parameter int NUM_Q = 32,
    parameter int BUS_W = 8,
    parameter int NQUAD = 4,
    parameter int QW    = 2
) (
    input  logic [NUM_Q-1:0] status,
    input  logic [QW-1:0]    sel,
    output logic [BUS_W-1:0] flags
);
    logic [BUS_W-1:0] slice [NQUAD];

    for (genvar g = 0; g < NQUAD; g++) begin : g_slice
        // Cut out the status bits of quadrant g.
        assign slice[g] = status[g*BUS_W +: BUS_W];
    end

    // Choose the selected quadrant.
    always_comb begin
        flags = slice[sel];
    end
endmodule

// File: rtl/aeflag_quad_bus.sv
// Module: top of the quadrant almost-empty flag bus.
// Direct mode shows a strobed, ID-checked quadrant; polled mode rotates
// through the quadrants with a sync at quadrant 0. Assumes NUM_Q/BUS_W is
// a power of two and the ID field sits at the top of the address bus.
module aeflag_quad_bus
    import aeflag_pkg::*;
#(
    parameter int NUM_Q  = DEF_NUM_Q,
    parameter int BUS_W  = DEF_BUS_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int ID_W   = DEF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  ae_status,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag_strobe,
    input  logic              poll_mode,
    input  logic [ID_W-1:0]   dev_id,
    output logic [BUS_W-1:0]  flag_bus,
    output logic              quad_sync
);
    localparam int NQUAD  = NUM_Q / BUS_W;
    localparam int QW     = (NQUAD > 1) ? $clog2(NQUAD) : 1;
    localparam int ID_LSB = ADDR_W - ID_W;

    flag_mode_e    mode;
    logic [QW-1:0] dir_q;
    logic [QW-1:0] poll_q;
    logic [QW-1:0] cur_q;
    logic          unused_mid;

    // Decode the mode select.
    always_comb begin
        mode = flag_mode_e'(poll_mode);
    end

    // Address bits between the quadrant and ID fields take no part.
    assign unused_mid = ^rd_addr[ID_LSB-1:QW];

    aeflag_dir_sel #(
        .QW   (QW),
        .ID_W (ID_W)
    ) u_dir_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_en  (mode == MODE_DIRECT),
        .strobe     (flag_strobe),
        .id_field   (rd_addr[ADDR_W-1:ID_LSB]),
        .dev_id     (dev_id),
        .quad_field (rd_addr[QW-1:0]),
        .dir_q      (dir_q)
    );

    aeflag_poll_ctr #(
        .NQUAD (NQUAD),
        .QW    (QW)
    ) u_poll_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll_en (mode == MODE_POLL),
        .poll_q  (poll_q)
    );

    // Pick the quadrant source by mode and mark quadrant 0 while polling.
    always_comb begin
        cur_q     = (mode == MODE_POLL) ? poll_q : dir_q;
        quad_sync = (mode == MODE_POLL) && (poll_q == '0);
    end

    aeflag_quad_mux #(
        .NUM_Q (NUM_Q),
        .BUS_W (BUS_W),
        .NQUAD (NQUAD),
        .QW    (QW)
    ) u_mux (
        .status (ae_status),
        .sel    (cur_q),
        .flags  (flag_bus)
    );
endmodule

// File: rtl/aeflag_quad_bus_chk.sv
// Module: assertion checker bound to the flag bus top.
// Observes ports plus the direct selection and shown quadrant.
module aeflag_quad_bus_chk #(
    parameter int NUM_Q  = 32,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 8,
    parameter int ID_W   = 3,
    parameter int QW     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_Q-1:0]  ae_status,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              flag_strobe,
    input logic              poll_mode,
    input logic [ID_W-1:0]   dev_id,
    input logic [BUS_W-1:0]  flag_bus,
    input logic              quad_sync,
    input logic [QW-1:0]     dir_q,
    input logic [QW-1:0]     cur_q
);
    logic take;

    always_comb begin
        take = !poll_mode && flag_strobe && (rd_addr[ADDR_W-1 -: ID_W] == dev_id);
    end

    AST_SYNC_SHOWS_Q0: assert property (@(posedge clk) disable iff (!rst_n)
        quad_sync |-> (flag_bus == ae_status[BUS_W-1:0])); // R7
    AST_SYNC_DIRECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_mode |-> !quad_sync); // R7
    AST_POLL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(poll_mode) && poll_mode) |-> (cur_q == QW'($past(cur_q) + 1'b1))); // R6
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (dir_q == $past(rd_addr[QW-1:0]))); // R3
    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(dir_q)); // R5
endmodule

bind aeflag_quad_bus aeflag_quad_bus_chk #(
    .NUM_Q  (NUM_Q),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .QW     (QW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ae_status   (ae_status),
    .rd_addr     (rd_addr),
    .flag_strobe (flag_strobe),
    .poll_mode   (poll_mode),
    .dev_id      (dev_id),
    .flag_bus    (flag_bus),
    .quad_sync   (quad_sync),
    .dir_q       (dir_q),
    .cur_q       (cur_q)
);

// File: tb/test_aeflag_quad_bus.sv
// Directed bench for the quadrant almost-empty flag bus.
module test_aeflag_quad_bus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ae_status = 32'hD4C3B2A1;
    logic [7:0]  rd_addr = '0;
    logic        flag_strobe = 1'b0;
    logic        poll_mode = 1'b0;
    logic [2:0]  dev_id = 3'd5;
    logic [7:0]  flag_bus;
    logic        quad_sync;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    aeflag_quad_bus i_aeflag_quad_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .ae_status   (ae_status),
        .rd_addr     (rd_addr),
        .flag_strobe (flag_strobe),
        .poll_mode   (poll_mode),
        .dev_id      (dev_id),
        .flag_bus    (flag_bus),
        .quad_sync   (quad_sync)
    );

    function automatic logic [7:0] quad_of(input int q);
        return ae_status[q*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Move to just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Present a strobed selection for one edge, then look at the bus.
    task automatic strobe_sel(input logic [7:0] addr, input logic stb);
        rd_addr     = addr;
        flag_strobe = stb;
        step();
        flag_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset(input logic pm);
        rst_n     = 1'b0;
        poll_mode = pm;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus", flag_bus, quad_of(0));
        chk("R1 sync", {7'd0, quad_sync}, {7'd0, pm});
    endtask

    task automatic t_direct();
        strobe_sel({3'd5, 3'b000, 2'd2}, 1'b1);
        chk("R3 select q2", flag_bus, quad_of(2));
        chk("R7 sync low direct", {7'd0, quad_sync}, 8'd0);
        strobe_sel({3'd5, 3'b101, 2'd1}, 1'b1);
        chk("R4 mid bits 101 q1", flag_bus, quad_of(1));
        strobe_sel({3'd5, 3'b111, 2'd3}, 1'b1);
        chk("R4 mid bits 111 q3", flag_bus, quad_of(3));
        strobe_sel({3'd2, 3'b000, 2'd0}, 1'b1);
        chk("R5 id mismatch", flag_bus, quad_of(3));
        strobe_sel({3'd5, 3'b000, 2'd0}, 1'b0);
        chk("R5 strobe low", flag_bus, quad_of(3));
    endtask

    task automatic t_bitmap();
        for (int i = 0; i < 8; i++) begin
            ae_status = 32'h1 << (24 + i);
            #1;
            chk("R2 bit map", flag_bus, 8'h1 << i);
        end
        ae_status = 32'hD4C3B2A1;
        #1;
        chk("R2 live follow", flag_bus, 8'hD4);
    endtask

    task automatic t_poll(input int rounds);
        for (int k = 1; k <= rounds * 4; k++) begin
            @(negedge clk);
            chk("R6 poll quadrant", flag_bus, quad_of(k % 4));
            chk("R7 sync", {7'd0, quad_sync}, {7'd0, (k % 4) == 0});
        end
    endtask

    task automatic t_poll_entry();
        step();
        poll_mode   = 1'b1;
        rd_addr     = {3'd5, 3'b000, 2'd1};
        flag_strobe = 1'b1;
        @(negedge clk);
        chk("R6 entry at q0", flag_bus, quad_of(0));
        chk("R7 entry sync", {7'd0, quad_sync}, 8'd1);
        t_poll(2);
        step();
        poll_mode   = 1'b0;
        flag_strobe = 1'b0;
        @(negedge clk);
        chk("R8 direct kept", flag_bus, quad_of(3));
        chk("R7 sync off", {7'd0, quad_sync}, 8'd0);
    endtask

    initial begin
        t_reset(1'b1);
        t_poll(2);
        t_reset(1'b0);
        t_direct();
        t_bitmap();
        t_poll_entry();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule